// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port that sits on a simple byte-wide register bus. Each pin can be set as an input or an output. Output pins drive the value held in a per-pin holding flop. Input pins are sampled through a two-stage synchronizer before any logic or read path uses them.

Data accesses go through a window of aliased addresses below the direction register. Inside that window, the word-address bits act as a per-pin mask. A write can therefore change any subset of output pins in one bus cycle, with no read-modify-write. A read returns only the selected pins and zeros everywhere else.

Bus accesses take one cycle and have no wait states. Read data is presented combinationally in the same cycle as the select. The direction register lives at the first offset above the window.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` = 0x00), every holding bit is 0 (`pin_out` = 0x00), and the direction register reads 0x00.
- R2: The direction register is at byte offset 0x400. Bit n = 1 makes pin n an output, and `pin_oe` shows the register value one clock after the write.
- R3: A write at an offset below 0x400 updates holding bit n with `bus_wdata[n]` only when address bit n+2 is 1. Every other holding bit keeps its value.
- R4: A data write has no effect on the holding bit of a pin whose direction bit is 0. Making that pin an output later does not apply the earlier write; the pin drives its old holding value until it is written again.
- R5: A read at an offset below 0x400 returns 0 in every bit n whose address bit n+2 is 0. Address bits [1:0] do not affect the result.
- R6: In a masked data read, a selected output pin returns its holding value and a selected input pin returns its synchronized input.
- R7: A change on `pin_in` becomes visible to data reads two rising clock edges after it is applied, and not after one.
- R8: Reads of any offset above 0x400, or of 0x401 to 0x403, return 0x00. Writes to those offsets change neither the direction register nor any holding bit.
- R9: `bus_rdata` is 0x00 in every cycle without a read (no select, or a write).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as the read |
| pin_in | input | 8 | Pin input levels (asynchronous) |
| pin_out | output | 8 | Pin output values (holding bits) |
| pin_oe | output | 8 | Pin output enables (direction register) |

## Verification
Two things can land in the same cycle and must stay independent:
- a new synchronized input value arriving at a pin, and
- a masked bus access to that same pin.

The bench provokes this by changing `pin_in` on an output pin in the cycle of a masked write to it. It then checks that the pin drives the written value and that a read returns the holding value, not the input. It then turns the pin into an input and checks that the read source switches to the already-settled synchronized value. The read path is also sampled one edge after an input change, where the old value must still be returned, and again one edge later.

// File: rtl/gpio_mp_pkg.sv
// Package: shared types for the address-masked GPIO port.
// Assumes: one bus access per cycle; decode classifies it into one kind.
package gpio_mp_pkg;

    // Classification of a bus offset
    typedef enum logic [1:0] {
        ACC_NONE     = 2'd0,
        ACC_DATA     = 2'd1,
        ACC_DIR      = 2'd2,
        ACC_UNMAPPED = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/gpio_mp_decode.sv
// Module: gpio_mp_decode
// Classifies a bus offset into data window, direction register or
// unmapped space, and extracts the per-pin mask from the word-address bits.
// Assumes: the window spans offsets below 2**(PINS+2); the direction
// register sits exactly at that boundary.
module gpio_mp_decode
    import gpio_mp_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int ADDR_W = 12
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [PINS-1:0]   mask
);
    localparam int MASK_LSB = 2;
    localparam int MASK_MSB = PINS + MASK_LSB - 1;
    localparam logic [ADDR_W-1:0] DIR_OFS = ADDR_W'(1) << (PINS + MASK_LSB);

    logic in_window;

    // Window membership: all bits above the mask field are zero
    assign in_window = (addr < DIR_OFS);

    // Mask field: word-address bits select pins
    assign mask = addr[MASK_MSB:MASK_LSB];

    // Access classification
    always_comb begin
        if (!sel)                 kind = ACC_NONE;
        else if (in_window)       kind = ACC_DATA;
        else if (addr == DIR_OFS) kind = ACC_DIR;
        else                      kind = ACC_UNMAPPED;
    end
endmodule

// File: rtl/gpio_mp_dir_reg.sv
// Module: gpio_mp_dir_reg
// Holds the per-pin direction bits (1 = output). A full-byte write
// replaces all bits.
// Assumes: synchronous active-low reset leaves every pin an input.
module gpio_mp_dir_reg #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] dir
);
    // Direction register update
    always_ff @(posedge clk) begin
        if (!rst_n)     dir <= '0;
        else if (wr_en) dir <= wdata;
    end
endmodule

// File: rtl/gpio_mp_out_hold.sv
// Module: gpio_mp_out_hold
// Per-pin output holding flops. A masked data write updates a bit only
// when its mask bit is set and the pin is currently an output.
// Assumes: mask and dir are stable in the write cycle.
module gpio_mp_out_hold #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PINS-1:0] mask,
    input  logic [PINS-1:0] dir,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] hold
);
    for (genvar n = 0; n < PINS; n++) begin : g_bit
        logic upd;

        // Per-pin write qualifier
        assign upd = wr_en & mask[n] & dir[n];

        // Per-pin holding flop
        always_ff @(posedge clk) begin
            if (!rst_n)   hold[n] <= 1'b0;
            else if (upd) hold[n] <= wdata[n];
        end
    end
endmodule

// File: rtl/gpio_mp_in_sync.sv
// Module: gpio_mp_in_sync
// Multi-stage synchronizer for the asynchronous pin inputs.
// Assumes: STAGES >= 2; every pin is synchronized independently.
module gpio_mp_in_sync #(
    parameter int PINS   = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] din,
    output logic [PINS-1:0] dout
);
    logic [PINS-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First capture stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= din;
            end
        end else begin : g_next
            // Follow-on settling stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_mp_rd_mux.sv
// Module: gpio_mp_rd_mux
// Builds read data. In the data window, each selected pin returns its
// holding bit if it is an output, or its synchronized input otherwise.
// The direction offset returns the direction bits; everything else
// returns 0.
// Assumes: rd_en is low in every cycle without a read.
module gpio_mp_rd_mux
    import gpio_mp_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            rd_en,
    input  acc_kind_e       kind,
    input  logic [PINS-1:0] mask,
    input  logic [PINS-1:0] dir,
    input  logic [PINS-1:0] hold,
    input  logic [PINS-1:0] sync_in,
    output logic [PINS-1:0] rdata
);
    logic [PINS-1:0] pin_val;

    // Per-pin read source: driven value for outputs, sampled input otherwise
    for (genvar n = 0; n < PINS; n++) begin : g_src
        assign pin_val[n] = dir[n] ? hold[n] : sync_in[n];
    end

    // Read data selection
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (kind)
                ACC_DATA: rdata = pin_val & mask;
                ACC_DIR:  rdata = dir;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_mask_port.sv
// Module: gpio_mask_port (top)
// Eight-pin GPIO port with a direction register and an address-masked
// data window, on a single-cycle byte-wide bus.
// Assumes: one access per cycle, no wait states, read data combinational.
module gpio_mask_port
    import gpio_mp_pkg::*;
#(
    parameter int PINS        = 8,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);
    acc_kind_e       kind;
    logic [PINS-1:0] mask;
    logic [PINS-1:0] dir;
    logic [PINS-1:0] hold;
    logic [PINS-1:0] sync_in;
    logic            data_wr;
    logic            dir_wr;
    logic            rd_en;

    // Access strobes
    assign data_wr = bus_wr  & (kind == ACC_DATA);
    assign dir_wr  = bus_wr  & (kind == ACC_DIR);
    assign rd_en   = bus_sel & ~bus_wr;

    gpio_mp_decode #(.PINS(PINS), .ADDR_W(ADDR_W)) u_decode (
        .sel  (bus_sel),
        .addr (bus_addr),
        .kind (kind),
        .mask (mask)
    );

    gpio_mp_dir_reg #(.PINS(PINS)) u_dir (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (dir_wr),
        .wdata (bus_wdata),
        .dir   (dir)
    );

    gpio_mp_out_hold #(.PINS(PINS)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (data_wr),
        .mask  (mask),
        .dir   (dir),
        .wdata (bus_wdata),
        .hold  (hold)
    );

    gpio_mp_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (sync_in)
    );

    gpio_mp_rd_mux #(.PINS(PINS)) u_rd (
        .rd_en   (rd_en),
        .kind    (kind),
        .mask    (mask),
        .dir     (dir),
        .hold    (hold),
        .sync_in (sync_in),
        .rdata   (bus_rdata)
    );

    assign pin_out = hold;
    assign pin_oe  = dir;
endmodule

// File: rtl/gpio_mp_checker.sv
// Module: gpio_mp_checker
// Port-level properties of gpio_mask_port, attached with bind.
// Assumes: default offsets (window below 2**(PINS+2), direction at it).
module gpio_mp_checker #(
    parameter int PINS   = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   pin_oe
);
    localparam logic [ADDR_W-1:0] DIR_OFS = ADDR_W'(1) << (PINS + 2);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == DIR_OFS) |=> (pin_oe == $past(bus_wdata)));

    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr > DIR_OFS) |-> (bus_rdata == '0));

    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr > DIR_OFS) |=> ($stable(pin_oe) && $stable(pin_out)));

    // R9
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel || bus_wr) |-> (bus_rdata == '0));

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        // R3
        unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_wr && bus_addr < DIR_OFS && !bus_addr[n+2])
            |=> $stable(pin_out[n]));

        // R4
        input_pin_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_wr && bus_addr < DIR_OFS && !pin_oe[n])
            |=> $stable(pin_out[n]));

        // R5
        unmasked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && !bus_wr && bus_addr < DIR_OFS && !bus_addr[n+2])
            |-> (bus_rdata[n] == 1'b0));

        // R6
        output_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && !bus_wr && bus_addr < DIR_OFS && bus_addr[n+2] && pin_oe[n])
            |-> (bus_rdata[n] == pin_out[n]));
    end
endmodule

bind gpio_mask_port gpio_mp_checker #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_mask_port_tb.sv
`timescale 1ns/1ps
module gpio_mask_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_mask_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    function automatic logic [11:0] win(logic [7:0] m);
        return {2'b00, m, 2'b00};
    endfunction

    // Write at negedge, commits on next posedge, bus idle again at negedge
    task automatic bus_write(logic [11:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    // Combinational read, sampled mid low phase
    task automatic bus_read(logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_addr = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        bus_read(12'h400, d);
        chk("R1 dir read", d, 8'h00);
        #1 chk("R9 idle rdata", bus_rdata, 8'h00);
    endtask

    task automatic t_direction();
        logic [7:0] d;
        bus_write(12'h400, 8'hF0);
        chk("R2 pin_oe", pin_oe, 8'hF0);
        bus_read(12'h400, d);
        chk("R2 dir readback", d, 8'hF0);
    endtask

    task automatic t_masked_write();
        bus_write(win(8'hFF), 8'hFF);
        chk("R3 full mask write", pin_out, 8'hF0);
        bus_write(win(8'h30), 8'h00);
        chk("R3 mask 0x30 clear", pin_out, 8'hC0);
        bus_write(win(8'h80), 8'h00);
        chk("R3 mask 0x80 clear", pin_out, 8'h40);
    endtask

    task automatic t_write_to_input();
        bus_write(win(8'h01), 8'h01);
        chk("R4 input pin write ignored", pin_out, 8'h40);
        bus_write(12'h400, 8'hF1);
        chk("R4 after turning output", pin_out, 8'h40);
        chk("R2 pin_oe F1", pin_oe, 8'hF1);
        bus_write(win(8'h01), 8'h01);
        chk("R4 rewrite applies", pin_out, 8'h41);
    endtask

    task automatic t_masked_read();
        logic [7:0] d;
        @(negedge clk) pin_in = 8'h0A;
        repeat (3) @(negedge clk);
        bus_read(win(8'hFF), d);
        chk("R6 full read mix", d, 8'h4B);
        bus_read(win(8'h0F), d);
        chk("R5 low nibble", d, 8'h0B);
        bus_read(12'h000, d);
        chk("R5 empty mask", d, 8'h00);
        bus_read(win(8'h40) | 12'h003, d);
        chk("R5 low addr bits ignored", d, 8'h40);
    endtask

    task automatic t_sync_latency();
        logic [7:0] d;
        @(negedge clk);
        pin_in = 8'h0E;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = win(8'h04);
        @(posedge clk);
        @(negedge clk);
        #1 chk("R7 one edge", bus_rdata, 8'h00);
        @(posedge clk);
        @(negedge clk);
        #1 chk("R7 two edges", bus_rdata, 8'h04);
        bus_sel = 1'b0; bus_addr = '0;
        pin_in = 8'h8E;
        repeat (3) @(negedge clk);
        bus_read(win(8'h80), d);
        chk("R6 output pin ignores input", d, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        bus_read(12'h404, d);
        chk("R8 read 0x404", d, 8'h00);
        bus_read(12'h401, d);
        chk("R8 read 0x401", d, 8'h00);
        bus_read(12'hFFC, d);
        chk("R8 read 0xFFC", d, 8'h00);
        bus_write(12'h404, 8'hFF);
        bus_write(12'h403, 8'h00);
        chk("R8 write keeps dir", pin_oe, 8'hF1);
        chk("R8 write keeps out", pin_out, 8'h41);
    endtask

    task automatic t_concurrent();
        logic [7:0] d;
        @(negedge clk);
        pin_in = 8'hCE;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = win(8'h40); bus_wdata = 8'h00;
        #1 chk("R9 rdata during write", bus_rdata, 8'h00);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
        chk("R3 write with input change", pin_out, 8'h01);
        repeat (2) @(negedge clk);
        bus_read(win(8'h40), d);
        chk("R6 holding value wins", d, 8'h00);
        bus_write(12'h400, 8'hB1);
        bus_read(win(8'h40), d);
        chk("R6 input after dir flip", d, 8'h40);
        chk("R4 holding kept on flip", pin_out, 8'h01);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_masked_write();
        t_write_to_input();
        t_masked_read();
        t_sync_latency();
        t_unmapped();
        t_concurrent();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule